// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects up to 24 interrupt requests and presents them to one processor as a single interrupt line plus an 8-bit vector. There are three groups of sources: 16 external lines, 4 internal peripheral sources and 4 global timer sources. Each source has a control register, which holds a mask, a 4-bit priority and an 8-bit vector. Each source also has a one-bit destination register. A rising edge on an enabled request line marks that source as pending. Whenever the controller evaluates, it promotes the best pending source to in-service and raises the processor interrupt.

Software works through a 32-bit register bus. Reading the acknowledge register evaluates the sources and returns the vector of the source in service. If no source is in service, the read returns the spurious vector. Writing the end-of-interrupt register retires the source in service and evaluates again. Only one source is in service at a time, and a priority of zero keeps a source from ever becoming pending.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every source is masked: its control register reads with bit 31 set and all other bits zero. No source is in service, `cpu_irq` is low, and the spurious vector and configuration registers read zero.
- R2: A source control register has the following fields: mask at bit 31, a read-only in-service flag at bit 30, priority in bits 19:16 and vector in bits 7:0. Writes to bit 30 and to the unused bits are dropped.
- R3: A rising edge on a request line marks that source pending only if the source is unmasked and its priority is non-zero at that moment. Otherwise the edge is lost.
- R4: Evaluation selects the pending source with the largest priority value. Among equal priorities, the lowest source number wins. Source numbers are: external lines 0-15, internal sources 16-19, timers 20-23.
- R5: An evaluation is triggered by a newly latched request, an acknowledge read or an effective end-of-interrupt write. If it finds a pending source while none is in service, that source stops being pending, becomes in service, and `cpu_irq` goes high on the next clock.
- R6: An acknowledge read (address 0x600A0) returns the in-service vector in bits 7:0, one cycle after the read strobe. An evaluation that takes no new source drives `cpu_irq` low.
- R7: An acknowledge read with no source in service after evaluation returns the spurious vector register (address 0x410E0, bits 7:0).
- R8: A write to the end-of-interrupt register (address 0x600B0) clears the in-service source and evaluates again. The same write with nothing in service changes nothing.
- R9: At most one source is in service at any time.
- R10: A destination register keeps only bit 0 of the written data and reads all other bits as zero.
- R11: A configuration write (address 0x41030) with bit 27 set, which requests serial mode, is dropped entirely. Any other configuration write is stored and reads back in full.
- R12: Reads of unmapped addresses return zero, and writes to them change no state.
- R13: A request edge that arrives while the same source is in service is latched as pending, and that source is taken again after end-of-interrupt.
- R14: The register addresses are as follows:
  - External control registers sit at 0x50200 + 0x20·i.
  - Internal control registers sit at 0x50400 + 0x20·k.
  - Timer control registers sit at 0x41120 + 0x40·t.
  - Each destination register sits 0x10 above its control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 24 | Request lines, asynchronous, rising-edge sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 20 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The bench uses the default parameters: 16 external, 4 internal and 4 timer sources, 4-bit priorities, 8-bit vectors and a two-stage request synchroniser. These defaults put an external line and a timer at the same top priority, so the lowest-number tie rule can be tested across two groups. They also reach a source in the internal group, whose registers sit above the external block. The 4-bit priority allows both a zero-priority disable and a strict ordering of three levels within one arbitration round.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_DEST,
        RK_ACK,
        RK_EOI,
        RK_SPUR,
        RK_CONF
    } reg_kind_e;

    localparam int unsigned EXT_CTRL_BASE = 32'h0005_0200;
    localparam int unsigned EXT_STEP      = 32'h0000_0020;
    localparam int unsigned INT_CTRL_BASE = 32'h0005_0400;
    localparam int unsigned INT_STEP      = 32'h0000_0020;
    localparam int unsigned TMR_CTRL_BASE = 32'h0004_1120;
    localparam int unsigned TMR_STEP      = 32'h0000_0040;
    localparam int unsigned DEST_OFFSET   = 32'h0000_0010;
    localparam int unsigned ACK_ADDR      = 32'h0006_00A0;
    localparam int unsigned EOI_ADDR      = 32'h0006_00B0;
    localparam int unsigned SPUR_ADDR     = 32'h0004_10E0;
    localparam int unsigned CONF_ADDR     = 32'h0004_1030;

    localparam int MASK_BIT   = 31;
    localparam int ACT_BIT    = 30;
    localparam int PRIO_LSB   = 16;
    localparam int SERIAL_BIT = 27;

    // Control register address of source idx, counting external, internal, then timers
    function automatic int unsigned ctrl_addr(int idx, int n_ext, int n_int);
        if (idx < n_ext)
            return EXT_CTRL_BASE + EXT_STEP * idx;
        else if (idx < n_ext + n_int)
            return INT_CTRL_BASE + INT_STEP * (idx - n_ext);
        else
            return TMR_CTRL_BASE + TMR_STEP * (idx - n_ext - n_int);
    endfunction

endpackage

// File: rtl/irq_vec_sync.sv
module irq_vec_sync #(
    parameter int NSRC   = 24,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_async,
    output logic [NSRC-1:0] req_rise
);
    logic [STAGES-1:0][NSRC-1:0] sync_d, sync_q;
    logic [NSRC-1:0]             prev_d, prev_q;

    always_comb begin
        sync_d[0] = req_async;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign req_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_vec_decode.sv
module irq_vec_decode
    import irq_vec_pkg::*;
#(
    parameter int NSRC   = 24,
    parameter int N_EXT  = 16,
    parameter int N_INT  = 4,
    parameter int ADDR_W = 20,
    parameter int SRC_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SRC_W-1:0]  src
);
    logic [NSRC-1:0] ctrl_hit;
    logic [NSRC-1:0] dest_hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int unsigned CA = ctrl_addr(g, N_EXT, N_INT);
        assign ctrl_hit[g] = (addr == ADDR_W'(CA));
        assign dest_hit[g] = (addr == ADDR_W'(CA + DEST_OFFSET));
    end

    always_comb begin
        src = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ctrl_hit[i] || dest_hit[i]) src = SRC_W'(i);
        end
        if (|ctrl_hit)                       kind = RK_CTRL;
        else if (|dest_hit)                  kind = RK_DEST;
        else if (addr == ADDR_W'(ACK_ADDR))  kind = RK_ACK;
        else if (addr == ADDR_W'(EOI_ADDR))  kind = RK_EOI;
        else if (addr == ADDR_W'(SPUR_ADDR)) kind = RK_SPUR;
        else if (addr == ADDR_W'(CONF_ADDR)) kind = RK_CONF;
        else                                 kind = RK_NONE;
    end
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
    parameter int NSRC   = 24,
    parameter int PRIO_W = 4,
    parameter int SRC_W  = 5
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        found,
    output logic [SRC_W-1:0]            win
);
    logic [PRIO_W-1:0] best;

    // Ascending scan with strict compare keeps the lowest index on a tie
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                win   = SRC_W'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N_EXT       = 16,
    parameter int N_INT       = 4,
    parameter int N_TMR       = 4,
    parameter int PRIO_W      = 4,
    parameter int VEC_W       = 8,
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_EXT+N_INT+N_TMR-1:0]    irq_req,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic                            cpu_irq
);
    localparam int NSRC  = N_EXT + N_INT + N_TMR;
    localparam int SRC_W = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]             mask;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NSRC-1:0][VEC_W-1:0]  vec;
        logic [NSRC-1:0]             dest;
        logic [NSRC-1:0]             pend;
        logic                        in_svc;
        logic [SRC_W-1:0]            act;
        logic [VEC_W-1:0]            ack_vec;
        logic [VEC_W-1:0]            spur;
        logic [DATA_W-1:0]           conf;
        logic                        irq;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NSRC-1:0]  req_rise;
    logic [NSRC-1:0]  req_en;
    logic [NSRC-1:0]  pend_mid;
    logic             arb_found;
    logic [SRC_W-1:0] arb_win;
    reg_kind_e        kind;
    logic [SRC_W-1:0] src;

    // Observation points for the bound checker
    logic             in_svc_q;
    logic [NSRC-1:0]  pend_q;
    logic [DATA_W-1:0] conf_q;

    irq_vec_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (irq_req),
        .req_rise  (req_rise)
    );

    irq_vec_decode #(
        .NSRC(NSRC), .N_EXT(N_EXT), .N_INT(N_INT), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
    ) i_decode (
        .addr (bus_addr),
        .kind (kind),
        .src  (src)
    );

    // Enable and newly latched pending set, ahead of arbitration
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            req_en[i] = !state_q.mask[i] && (state_q.prio[i] != '0);
        end
        pend_mid = state_q.pend | (req_rise & req_en);
    end

    irq_vec_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) i_arb (
        .cand  (pend_mid),
        .prio  (state_q.prio),
        .found (arb_found),
        .win   (arb_win)
    );

    logic              eoi_go;
    logic              ack_go;
    logic              eval;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        state_d = state_q;
        state_d.pend = pend_mid;

        eoi_go = bus_wr && (kind == RK_EOI) && state_q.in_svc;
        ack_go = bus_rd && (kind == RK_ACK);
        eval   = eoi_go || ack_go || (|(req_rise & req_en));

        if (eoi_go) state_d.in_svc = 1'b0;

        if (bus_wr) begin
            unique case (kind)
                RK_CTRL: begin
                    state_d.mask[src] = bus_wdata[MASK_BIT];
                    state_d.prio[src] = bus_wdata[PRIO_LSB +: PRIO_W];
                    state_d.vec[src]  = bus_wdata[VEC_W-1:0];
                end
                RK_DEST: state_d.dest[src] = bus_wdata[0];
                RK_SPUR: state_d.spur = bus_wdata[VEC_W-1:0];
                RK_CONF: if (!bus_wdata[SERIAL_BIT]) state_d.conf = bus_wdata;
                default: ;
            endcase
        end

        if (eval) begin
            if (arb_found && !state_d.in_svc) begin
                state_d.pend[arb_win] = 1'b0;
                state_d.in_svc        = 1'b1;
                state_d.act           = arb_win;
                state_d.ack_vec       = state_q.vec[arb_win];
                state_d.irq           = 1'b1;
            end else begin
                state_d.irq = 1'b0;
            end
        end

        rd_val = '0;
        unique case (kind)
            RK_CTRL: begin
                rd_val[MASK_BIT]             = state_q.mask[src];
                rd_val[ACT_BIT]              = state_q.in_svc && (state_q.act == src);
                rd_val[PRIO_LSB +: PRIO_W]   = state_q.prio[src];
                rd_val[VEC_W-1:0]            = state_q.vec[src];
            end
            RK_DEST: rd_val[0]         = state_q.dest[src];
            RK_SPUR: rd_val[VEC_W-1:0] = state_q.spur;
            RK_CONF: rd_val            = state_q.conf;
            RK_ACK:  rd_val[VEC_W-1:0] = state_d.in_svc ? state_d.ack_vec : state_q.spur;
            default: rd_val            = '0;
        endcase
        if (bus_rd) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mask <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign cpu_irq   = state_q.irq;
    assign in_svc_q  = state_q.in_svc;
    assign pend_q    = state_q.pend;
    assign conf_q    = state_q.conf;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
    import irq_vec_pkg::*;
#(
    parameter int NSRC   = 24,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              cpu_irq,
    input logic              in_svc_q,
    input logic [NSRC-1:0]   req_rise,
    input logic [NSRC-1:0]   req_en,
    input logic [NSRC-1:0]   pend_q,
    input logic [DATA_W-1:0] conf_q
);
    logic at_ack, at_eoi, at_conf;
    assign at_ack  = (bus_addr == ADDR_W'(ACK_ADDR));
    assign at_eoi  = (bus_addr == ADDR_W'(EOI_ADDR));
    assign at_conf = (bus_addr == ADDR_W'(CONF_ADDR));

    p_irq_needs_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> in_svc_q);

    p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && at_ack && in_svc_q) |=> !cpu_irq);

    p_eoi_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && at_eoi && in_svc_q) |=> (cpu_irq || !in_svc_q));

    p_eoi_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && at_eoi && !in_svc_q && !(|(req_rise & req_en)))
        |=> ($stable(cpu_irq) && !in_svc_q));

    p_serial_conf_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_conf && bus_wdata[SERIAL_BIT]) |=> $stable(conf_q));

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        p_pend_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[g]) |-> $past(req_en[g]));
    end
endmodule

bind irq_vec_ctrl irq_vec_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cpu_irq   (cpu_irq),
    .in_svc_q  (in_svc_q),
    .req_rise  (req_rise),
    .req_en    (req_en),
    .pend_q    (pend_q),
    .conf_q    (conf_q)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
    localparam int NSRC = 24;
    localparam int NV   = 64;
    localparam logic [1:0] OW = 2'd0, OR = 2'd1, OQ = 2'd2, OI = 2'd3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [19:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            cpu_irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    irq_vec_ctrl i_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    // {op, addr, data, expected, requirement}
    localparam logic [89:0] TBL [NV] = '{
        {OR, 20'h50200, 32'h0,        32'h80000000, 4'd1},  // R1
        {OR, 20'h600A0, 32'h0,        32'h00000000, 4'd7},  // R7
        {OI, 20'h0,     32'h0,        32'h00000000, 4'd1},  // R1
        {OW, 20'h410E0, 32'h000000FF, 32'h0,        4'd14}, // R14
        {OR, 20'h410E0, 32'h0,        32'h000000FF, 4'd14}, // R14
        {OR, 20'h600A0, 32'h0,        32'h000000FF, 4'd7},  // R7
        {OW, 20'h50260, 32'h00050033, 32'h0,        4'd2},  // R2
        {OR, 20'h50260, 32'h0,        32'h00050033, 4'd2},  // R2
        {OW, 20'h50260, 32'h40050033, 32'h0,        4'd2},  // R2
        {OR, 20'h50260, 32'h0,        32'h00050033, 4'd2},  // R2
        {OQ, 20'h0,     32'h00000008, 32'h0,        4'd5},  // R5
        {OI, 20'h0,     32'h0,        32'h00000001, 4'd5},  // R5
        {OR, 20'h50260, 32'h0,        32'h40050033, 4'd2},  // R2
        {OR, 20'h600A0, 32'h0,        32'h00000033, 4'd6},  // R6
        {OI, 20'h0,     32'h0,        32'h00000000, 4'd6},  // R6
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd8},  // R8
        {OR, 20'h50260, 32'h0,        32'h00050033, 4'd8},  // R8
        {OW, 20'h502A0, 32'h80070055, 32'h0,        4'd3},  // R3
        {OQ, 20'h0,     32'h00000020, 32'h0,        4'd3},  // R3
        {OI, 20'h0,     32'h0,        32'h00000000, 4'd3},  // R3
        {OW, 20'h502A0, 32'h00070055, 32'h0,        4'd3},  // R3
        {OR, 20'h600A0, 32'h0,        32'h000000FF, 4'd3},  // R3
        {OW, 20'h502C0, 32'h00000066, 32'h0,        4'd3},  // R3
        {OQ, 20'h0,     32'h00000040, 32'h0,        4'd3},  // R3
        {OR, 20'h600A0, 32'h0,        32'h000000FF, 4'd3},  // R3
        {OW, 20'h41120, 32'h000700A0, 32'h0,        4'd14}, // R14
        {OW, 20'h502E0, 32'h00020077, 32'h0,        4'd4},  // R4
        {OQ, 20'h0,     32'h00000008, 32'h0,        4'd4},  // R4
        {OQ, 20'h0,     32'h001000A0, 32'h0,        4'd4},  // R4
        {OI, 20'h0,     32'h0,        32'h00000000, 4'd4},  // R4
        {OR, 20'h600A0, 32'h0,        32'h00000033, 4'd9},  // R9
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd4},  // R4
        {OI, 20'h0,     32'h0,        32'h00000001, 4'd4},  // R4
        {OR, 20'h600A0, 32'h0,        32'h00000055, 4'd4},  // R4
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd4},  // R4
        {OR, 20'h600A0, 32'h0,        32'h000000A0, 4'd4},  // R4
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd4},  // R4
        {OR, 20'h600A0, 32'h0,        32'h00000077, 4'd4},  // R4
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd8},  // R8
        {OI, 20'h0,     32'h0,        32'h00000000, 4'd8},  // R8
        {OR, 20'h600A0, 32'h0,        32'h000000FF, 4'd8},  // R8
        {OQ, 20'h0,     32'h00000008, 32'h0,        4'd13}, // R13
        {OQ, 20'h0,     32'h00000008, 32'h0,        4'd13}, // R13
        {OR, 20'h600A0, 32'h0,        32'h00000033, 4'd13}, // R13
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd13}, // R13
        {OI, 20'h0,     32'h0,        32'h00000001, 4'd13}, // R13
        {OR, 20'h600A0, 32'h0,        32'h00000033, 4'd13}, // R13
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd8},  // R8
        {OW, 20'h600B0, 32'h0,        32'h0,        4'd8},  // R8
        {OR, 20'h600A0, 32'h0,        32'h000000FF, 4'd8},  // R8
        {OW, 20'h50270, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
        {OR, 20'h50270, 32'h0,        32'h00000001, 4'd10}, // R10
        {OW, 20'h41170, 32'h00000002, 32'h0,        4'd10}, // R10
        {OR, 20'h41170, 32'h0,        32'h00000000, 4'd10}, // R10
        {OW, 20'h41030, 32'h00000005, 32'h0,        4'd11}, // R11
        {OR, 20'h41030, 32'h0,        32'h00000005, 4'd11}, // R11
        {OW, 20'h41030, 32'h08000001, 32'h0,        4'd11}, // R11
        {OR, 20'h41030, 32'h0,        32'h00000005, 4'd11}, // R11
        {OW, 20'h50204, 32'h12345678, 32'h0,        4'd12}, // R12
        {OR, 20'h50204, 32'h0,        32'h00000000, 4'd12}, // R12
        {OR, 20'h50260, 32'h0,        32'h00050033, 4'd12}, // R12
        {OW, 20'h50420, 32'h000300C1, 32'h0,        4'd14}, // R14
        {OQ, 20'h0,     32'h00020000, 32'h0,        4'd14}, // R14
        {OR, 20'h600A0, 32'h0,        32'h000000C1, 4'd14}  // R14
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata, e, req);
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk);
        irq_req = irq_req | m;
        repeat (2) @(negedge clk);
        irq_req = irq_req & ~m;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            logic [89:0] e;
            e = TBL[k];
            unique case (e[89:88])
                OW: do_write(e[87:68], e[67:36]);
                OR: do_read(e[87:68], e[35:4], int'(e[3:0]));
                OQ: pulse(e[36 +: NSRC]);
                default: begin
                    @(negedge clk);
                    check({31'b0, cpu_irq}, e[35:4], int'(e[3:0]));
                end
            endcase
        end

        // R1: reset in the middle of service returns everything to the idle state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check({31'b0, cpu_irq}, 32'h0, 1);
        do_read(20'h50420, 32'h80000000, 1);
        do_read(20'h50260, 32'h80000000, 1);
        do_read(20'h410E0, 32'h0, 1);
        do_read(20'h41030, 32'h0, 1);
        do_read(20'h600A0, 32'h0, 7);
        // R3: masked after reset, so a request edge leaves nothing pending
        pulse(24'h000008);
        check({31'b0, cpu_irq}, 32'h0, 3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule